// File: doc/BRIEF.md
# Six-Step Control Phase Sequencer

This block gives a small processor control unit its sense of order. It drives six step lines, numbered 0 to 5, and exactly one of them is high at any time. Control logic elsewhere ANDs each of its actions with one step line, so an action fires only in the step it belongs to. Each full period of the step-clock input (a low phase followed by a high phase) moves the active step on by one. After step 5 the block returns to step 0, and every round is exactly six step-clock periods long.

Inside the block is a chain of master/slave storage pairs. All of them are flip-flops on the fast system clock. The level of the step clock decides which half of the chain may load. Masters load while the step clock is low, and slaves copy their masters while it is high. A token is fed in at the head of the chain, so the slaves fill up as a thermometer code. The block decodes the step lines from adjacent slave pairs. When the last master is set and the high phase begins, the whole chain clears in that same system-clock cycle. No seventh, transitional step ever appears on the outputs. A synchronous reset also clears the chain and forces step 0 in any phase of the step clock. The step clock must stay at each level for at least two system-clock cycles.

Top module: `step_sequencer`

## Requirements
- R1: While `rst` is high, `step` equals 6'b000001. Step 0 is line bit 0 and step k is bit k. In the first cycle after `rst` goes low, `step` is still 6'b000001.
- R2: `step` has exactly one bit set in every system-clock cycle, including the cycles where the active step changes.
- R3: The active step advances by exactly one, from k to k+1, in the first system-clock cycle after the step clock goes high. The step clock must have been low for at least one sampled cycle since the previous advance. The advance does not depend on how long each phase lasts.
- R4: Holding the step clock low for any number of cycles never changes `step`. Holding it high for any number of cycles advances `step` at most once.
- R5: The step after step 5 is step 0, with no other output pattern between them. Every round from one entry into step 0 to the next lasts exactly six step-clock periods.
- R6: Asserting `rst` in the middle of a round returns `step` to step 0, whether the step clock is low or high at the time. The next full step-clock period after release then gives step 1.
- R7: If `rst` is released while the step clock is high, `step` stays at step 0 until a low phase and then a high phase have followed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; every storage element loads on its rising edge |
| rst | input | 1 | Synchronous reset; clears the chain and forces step 0 |
| step_clk | input | 1 | Step-clock level; low lets masters load, high lets slaves copy |
| step | output | NSTEP | One-hot step lines, bit k is step k |

## Verification
The step clock is driven with balanced short phases, with lopsided long-low and long-high phases, and with phases held for many cycles. These patterns separate a design that advances once per period from one that counts system-clock cycles or edges inside a phase. Several back-to-back rounds show that the wrap from step 5 to step 0 costs no extra period and shows no pattern in between. Reset is asserted in a low phase, in a high phase and at the start of a high phase. This shows that a reset clears the masters as well as the slaves, and that a reset released mid-high does not let the stale token advance.

// File: rtl/step_sequencer.sv
module step_sequencer #(
  parameter int NSTEP = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_clk,
  output logic [NSTEP-1:0] step
);

  logic [NSTEP-1:0] mst, slv, mst_d;
  logic m_en, s_en, sentinel, clr;

  assign mst_d    = {slv[NSTEP-2:0], 1'b1};
  assign m_en     = ~step_clk;
  assign s_en     = step_clk;
  assign sentinel = s_en & mst[NSTEP-1];
  assign clr      = rst | sentinel;

  always_ff @(posedge clk) begin
    if (clr) begin
      mst <= '0;
      slv <= '0;
    end else begin
      if (m_en) mst <= mst_d;
      if (s_en) slv <= mst;
    end
  end

  assign step[0] = rst | ~slv[0];

  for (genvar k = 1; k < NSTEP; k++) begin : g_step
    assign step[k] = ~rst & slv[k-1] & ~slv[k];
  end

  p_reset_clears_r1: assert property (@(posedge clk) rst |=> (slv == '0 && mst == '0));

  p_onehot_r2: assert property (@(posedge clk) $countones(step) == 1);

  p_thermometer_r3: assert property (@(posedge clk) disable iff (rst)
    (slv & (slv + NSTEP'(1))) == '0);

  p_low_holds_r4: assert property (@(posedge clk) disable iff (rst)
    !step_clk |=> $stable(slv));

  p_wrap_to_zero_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(step[NSTEP-1]) |-> step[0]);

endmodule

// File: tb/step_sequencer_tb.sv
`timescale 1ns/1ps
module step_sequencer_tb;
  localparam int NSTEP = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic step_clk = 1'b0;
  logic [NSTEP-1:0] step;

  int checks = 0;
  int failures = 0;
  int mpos = 0;
  bit armed = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  step_sequencer #(.NSTEP(NSTEP)) u_dut (
    .clk(clk), .rst(rst), .step_clk(step_clk), .step(step)
  );

  task automatic check(input string req, input logic [NSTEP-1:0] exp);
    checks++;
    if (step !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, step, exp, $time);
    end
  endtask

  // behavioural reference, compared each cycle
  always @(posedge clk) begin
    if (rst) begin
      mpos = 0; armed = 1'b0;
    end else if (!step_clk) begin
      armed = 1'b1;
    end else if (armed) begin
      mpos = (mpos + 1) % NSTEP;
      armed = 1'b0;
    end
    #1;
    if (!done) begin
      check("R3 model", NSTEP'(1) << mpos);
      checks++;
      if ($countones(step) != 1) begin
        failures++;
        $display("FAIL R2 actual=%b expected=one-hot", step);
      end
    end
  end

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic period(input int lo, input int hi);
    @(negedge clk); step_clk = 1'b0;
    cycles(lo - 1);
    @(negedge clk); step_clk = 1'b1;
    cycles(hi - 1);
    @(negedge clk);
  endtask

  initial begin
    cycles(3);
    check("R1 during reset", 6'b000001);
    @(negedge clk); rst = 1'b0;
    check("R1 first cycle after release", 6'b000001);

    // R4: long low hold then long high hold
    step_clk = 1'b0; cycles(20);
    check("R4 low hold", 6'b000001);
    step_clk = 1'b1; cycles(20);
    check("R4 high hold advances once", 6'b000010);

    // R3: varied phase lengths
    period(2, 2);  check("R3 balanced", 6'b000100);
    period(7, 2);  check("R3 long low", 6'b001000);
    period(2, 9);  check("R3 long high", 6'b010000);
    period(3, 5);  check("R3 odd", 6'b100000);
    period(2, 2);  check("R5 wrap to step0", 6'b000001);

    // R5: three rounds of six periods
    for (int r = 0; r < 3; r++) begin
      for (int p = 1; p < NSTEP; p++) begin
        period(2 + r, 2 + p % 3);
        check("R5 round order", NSTEP'(1) << p);
      end
      period(3, 2);
      check("R5 round of six", 6'b000001);
    end

    // R6: reset during high phase
    period(2, 2); period(2, 2);
    check("R6 pre", 6'b000100);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); check("R6 reset in high", 6'b000001);
    rst = 1'b0; step_clk = 1'b0;
    period(2, 2); check("R6 restart after high reset", 6'b000010);
    // R6: reset during low phase (master already loaded)
    period(2, 2); period(2, 2);
    @(negedge clk); step_clk = 1'b0; cycles(2);
    rst = 1'b1; @(negedge clk);
    check("R6 reset in low", 6'b000001);
    rst = 1'b0; cycles(3);
    step_clk = 1'b1; cycles(3);
    check("R6 restart after low reset", 6'b000010);

    // R7: release reset in high phase with stale token
    period(2, 2); period(2, 2);
    @(negedge clk); step_clk = 1'b0; cycles(2);
    step_clk = 1'b1; rst = 1'b1; cycles(2);
    rst = 1'b0; cycles(10);
    check("R7 no advance after high release", 6'b000001);
    period(2, 2);
    check("R7 advance after full period", 6'b000010);

    done = 1'b1;
    cycles(2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    done = 1'b1;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule